// File: doc/BRIEF.md
# Converter Command and Conversion Controller

This block is the digital control core of a serially programmed delta-sigma converter. A bus slave outside the block turns the serial bus into whole bytes and hands them in over a byte stream. The block decodes each byte as a command and keeps a one-byte configuration register and a status register. It tells a modelled converter when to begin a conversion. Each 24-bit result that comes back is kept in a result buffer. Bytes for register reads and data reads go out over a second byte stream.

Two stream interfaces carry data, and both use valid/ready. On the command stream, a byte is taken on any clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low while read-back bytes are still waiting. Because of this, a read's reply is always drained before the next command can be taken. On the read-back stream, a byte leaves on an edge where `rd_valid` and `rd_ready` are both high. While `rd_ready` is low, the pending byte stays on `rd_data` without change. The converter side uses plain pins: a one-cycle `conv_start` pulse goes out, and a one-cycle `conv_done` strobe comes back together with `conv_result`.

Configuration bit 1 selects the conversion mode. With it clear, one start command gives exactly one conversion, and the block then returns to idle. With it set, a new conversion is requested each time one completes. `drdy_n` is the inverse of the data-ready flag in status bit 7.

Top module: `adc_cmd_ctrl`

## Requirements
- R1: After reset, `cmd_ready`=1, `rd_valid`=0, `conv_start`=0 and `drdy_n`=1. Both the configuration register and the status register read back as 0x00.
- R2: A byte matching 0000011x (0x06 or 0x07) has these effects: configuration, status flag and stored result all become zero, and any conversion in progress is abandoned with no further `conv_start`.
- R3: A byte matching 0000100x (0x08 or 0x09) raises `conv_start` for one cycle, in the cycle after the byte is accepted. If this byte arrives while a conversion is running, the conversion is restarted: a new pulse is issued and only the `conv_done` that follows it is counted.
- R4: A byte matching 0000001x (0x02 or 0x03) ends conversion activity. No `conv_start` follows it. A `conv_done` that arrives afterwards changes neither the flag nor the result.
- R5: A byte matching 0001xxxx returns three bytes of the stored result, most significant byte first. The value is captured when the command is accepted. The data-ready flag is cleared, so `drdy_n` rises.
- R6: A byte matching 00100rxx returns one byte. Bit 2 (r) picks the register: 0 gives the configuration register, and 1 gives the status register. In the status byte, bit 7 is the data-ready flag and bits 6..0 are zero.
- R7: A byte matching 010000xx marks the next accepted byte as data for the configuration register. That data byte is written whatever its value, even if it looks like a command.
- R8: Single-shot mode (configuration bit 1 = 0): after an accepted `conv_done`, no further `conv_start` is issued, the result is stored and `drdy_n` goes low.
- R9: Continuous mode (configuration bit 1 = 1): every accepted `conv_done` is followed by a `conv_start` pulse in the next cycle.
- R10: A `conv_done` that arrives while no conversion is running is ignored.
- R11: While `rd_valid`=1 and `rd_ready`=0, `rd_data` and `rd_valid` hold their values. `cmd_ready` stays 0 while any read-back byte is pending.
- R12: Byte values that match none of the patterns above (for example 0x00, 0x0A, 0x30, 0x44, 0x55) change no state and produce no output.
- R13: A read-data byte may be accepted in the same cycle as a `conv_done`. In that case the reply carries the result from before that completion, and the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte valid |
| cmd_ready | output | 1 | Command byte can be accepted |
| cmd_data | input | 8 | Command or configuration data byte |
| rd_valid | output | 1 | Read-back byte valid |
| rd_ready | input | 1 | Consumer takes read-back byte |
| rd_data | output | 8 | Read-back byte |
| conv_start | output | 1 | One-cycle request to begin a conversion |
| conv_done | input | 1 | One-cycle strobe: conversion finished |
| conv_result | input | 24 | Result that comes with `conv_done` |
| drdy_n | output | 1 | Low while a new result is unread |

## Verification
The hardest case to reach from the ports is a command landing on the exact edge where a conversion completes. This covers a data read that must return the older value, and a start or stop that must cancel the completion. To reach it, the bench runs a converter model with a fixed latency and watches its strobe half a cycle ahead. When the strobe is about to rise, the bench presents a read-data byte at once, so that acceptance and completion share one clock edge. A behavioural reference model, built from queues and flags, predicts the stream outputs, the start pulse and `drdy_n` on every cycle. This catches the other orderings as well: a restart during a conversion, a stop with a conversion still in flight, and a read-back held up by the consumer.

// File: rtl/adc_cmd_pkg.sv
package adc_cmd_pkg;

  localparam int CMD_W = 8;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_RESET,
    OP_START,
    OP_PDOWN,
    OP_RDATA,
    OP_RREG,
    OP_WREG,
    OP_WDATA
  } op_e;

  typedef enum logic {
    SEQ_IDLE,
    SEQ_CONV
  } seq_e;

  function automatic op_e classify(input logic [CMD_W-1:0] b);
    op_e r;
    casez (b)
      8'b0000_011?: r = OP_RESET;
      8'b0000_100?: r = OP_START;
      8'b0000_001?: r = OP_PDOWN;
      8'b0001_????: r = OP_RDATA;
      8'b0010_0???: r = OP_RREG;
      8'b0100_00??: r = OP_WREG;
      default:      r = OP_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/adc_cmd_decode.sv
module adc_cmd_decode
  import adc_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [CMD_W-1:0] cmd_byte,
  output op_e              op,
  output logic             reg_sel
);

  logic wdata_pend_q;

  always_comb begin
    op = OP_NONE;
    if (fire) begin
      if (wdata_pend_q) op = OP_WDATA;
      else              op = classify(cmd_byte);
    end
  end

  assign reg_sel = cmd_byte[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_pend_q <= 1'b0;
    end else if (fire) begin
      wdata_pend_q <= (op == OP_WREG);
    end
  end

  // R7
  wreg_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WREG) |=> (fire -> op == OP_WDATA));

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic stop_req,
  input  logic done_in,
  input  logic cont_mode,
  output logic conv_start,
  output logic done_take,
  output logic busy
);

  seq_e state_q;
  logic start_q;

  assign busy       = (state_q == SEQ_CONV);
  assign conv_start = start_q;
  assign done_take  = done_in && busy && !start_req && !stop_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (stop_req) begin
        state_q <= SEQ_IDLE;
      end else if (start_req) begin
        state_q <= SEQ_CONV;
        start_q <= 1'b1;
      end else if (done_take) begin
        if (cont_mode) start_q <= 1'b1;
        else           state_q <= SEQ_IDLE;
      end
    end
  end

  // R8
  single_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_take && !cont_mode) |=> (!busy && !conv_start));

  // R9
  cont_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_take && cont_mode) |=> conv_start);

  // R4
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (!conv_start && !busy));

endmodule

// File: rtl/adc_readback.sv
module adc_readback #(
  parameter int BYTE_W    = 8,
  parameter int MAX_BYTES = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_en,
  input  logic [BYTE_W*MAX_BYTES-1:0]   load_word,
  input  logic [$clog2(MAX_BYTES+1)-1:0] load_cnt,
  input  logic                          rd_ready,
  output logic                          rd_valid,
  output logic [BYTE_W-1:0]             rd_data,
  output logic                          empty
);

  localparam int WORD_W = BYTE_W * MAX_BYTES;
  localparam int CNT_W  = $clog2(MAX_BYTES + 1);

  logic [WORD_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;

  assign rd_valid = (cnt_q != '0);
  assign empty    = (cnt_q == '0);
  assign rd_data  = shreg_q[WORD_W-1 -: BYTE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (load_en) begin
      shreg_q <= load_word;
      cnt_q   <= load_cnt;
    end else if (rd_valid && rd_ready) begin
      shreg_q <= shreg_q << BYTE_W;
      cnt_q   <= cnt_q - 1'b1;
    end
  end

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

endmodule

// File: rtl/adc_cmd_ctrl.sv
module adc_cmd_ctrl
  import adc_cmd_pkg::*;
#(
  parameter int RES_W         = 24,
  parameter int MODE_BIT      = 1,
  parameter int FLAG_BIT      = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [CMD_W-1:0] cmd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [CMD_W-1:0] rd_data,
  output logic             conv_start,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic             drdy_n
);

  localparam int RES_BYTES = RES_W / CMD_W;
  localparam int CNT_W     = $clog2(RES_BYTES + 1);

  op_e              op;
  logic             reg_sel;
  logic             cmd_fire;
  logic             rb_empty;
  logic             done_take;
  logic             busy;
  logic             start_req;
  logic             stop_req;
  logic [CMD_W-1:0] cfg_q;
  logic             flag_q;
  logic [RES_W-1:0] result_q;
  logic [CMD_W-1:0] reg_byte;
  logic [RES_W-1:0] load_word;
  logic [CNT_W-1:0] load_cnt;
  logic             load_en;

  assign cmd_ready = rb_empty;
  assign cmd_fire  = cmd_valid && rb_empty;
  assign start_req = (op == OP_START);
  assign stop_req  = (op == OP_RESET) || (op == OP_PDOWN);
  assign drdy_n    = ~flag_q;

  adc_cmd_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (cmd_fire),
    .cmd_byte (cmd_data),
    .op       (op),
    .reg_sel  (reg_sel)
  );

  adc_conv_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req),
    .stop_req   (stop_req),
    .done_in    (conv_done),
    .cont_mode  (cfg_q[MODE_BIT]),
    .conv_start (conv_start),
    .done_take  (done_take),
    .busy       (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      flag_q   <= 1'b0;
      result_q <= '0;
    end else if (op == OP_RESET) begin
      cfg_q    <= '0;
      flag_q   <= 1'b0;
      result_q <= '0;
    end else begin
      if (op == OP_WDATA) cfg_q <= cmd_data;
      if (done_take) begin
        result_q <= conv_result;
        flag_q   <= 1'b1;
      end else if (op == OP_RDATA) begin
        flag_q   <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_byte           = '0;
    reg_byte[FLAG_BIT] = flag_q;
    if (!reg_sel) reg_byte = cfg_q;
  end

  assign load_en   = (op == OP_RDATA) || (op == OP_RREG);
  assign load_word = (op == OP_RDATA) ? result_q
                                      : {reg_byte, {(RES_W-CMD_W){1'b0}}};
  assign load_cnt  = (op == OP_RDATA) ? CNT_W'(RES_BYTES) : CNT_W'(1);

  adc_readback #(
    .BYTE_W    (CMD_W),
    .MAX_BYTES (RES_BYTES)
  ) u_rb (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_word (load_word),
    .load_cnt  (load_cnt),
    .rd_ready  (rd_ready),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .empty     (rb_empty)
  );

  // R8
  done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_take |=> !drdy_n);

  // R5
  rdata_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RDATA && !done_take) |=> (drdy_n && rd_valid));

  // R10
  idle_done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !busy && op != OP_RESET) |=> $stable(result_q));

  // R11
  no_cmd_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !cmd_ready);

endmodule

// File: tb/adc_cmd_ctrl_tb_top.sv
module adc_cmd_ctrl_tb_top;

  localparam int LAT = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_data = 8'h00;
  logic        rd_valid;
  logic        rd_ready = 1'b1;
  logic [7:0]  rd_data;
  logic        conv_start;
  logic        conv_done = 1'b0;
  logic [23:0] conv_result = 24'h0;
  logic        drdy_n;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    finished = 1'b0;

  // converter model
  int          cv_cnt = 0;
  logic [23:0] cv_val = 24'h3C_5A_01;
  bit          force_done = 1'b0;
  int          pulse_cnt = 0;
  int          done_seen = 0;

  // reference model
  logic [7:0]  mq[$];
  logic [7:0]  m_cfg, m_cfg_old;
  logic        m_flag, m_run, m_pulse, m_wpend;
  logic [23:0] m_res;
  logic [7:0]  got_q[$];

  always #4 clk = ~clk;

  adc_cmd_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .conv_start(conv_start), .conv_done(conv_done), .conv_result(conv_result),
    .drdy_n(drdy_n)
  );

  always @(negedge clk) begin
    if (conv_start) cv_cnt = LAT;
    else if (cv_cnt > 0) cv_cnt = cv_cnt - 1;
    if (cv_cnt == 1) begin
      cv_val = cv_val * 24'd37 + 24'h1B_2D_77;
      conv_result = cv_val;
    end
    conv_done = (cv_cnt == 1) || force_done;
  end

  always @(posedge clk) begin
    if (conv_start) pulse_cnt++;
    if (conv_done)  done_seen++;
    if (rd_valid && rd_ready) got_q.push_back(rd_data);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      m_cfg = 8'h00; m_flag = 1'b0; m_run = 1'b0; m_pulse = 1'b0;
      m_wpend = 1'b0; m_res = 24'h0;
    end else begin
      bit acc, kill, dok;
      acc = cmd_valid && (mq.size() == 0);
      if (rd_ready && mq.size() > 0) void'(mq.pop_front());
      m_cfg_old = m_cfg;
      m_pulse = 1'b0;
      kill = 1'b0;
      if (acc && m_wpend) begin
        m_cfg = cmd_data; m_wpend = 1'b0;
      end else if (acc) begin
        casez (cmd_data)
          8'b0000_011?: begin m_cfg = 0; m_flag = 0; m_res = 0; m_run = 0; kill = 1; end
          8'b0000_100?: begin m_run = 1; m_pulse = 1; kill = 1; end
          8'b0000_001?: begin m_run = 0; kill = 1; end
          8'b0001_????: begin
            mq.push_back(m_res[23:16]); mq.push_back(m_res[15:8]); mq.push_back(m_res[7:0]);
            m_flag = 0;
          end
          8'b0010_0???: mq.push_back(cmd_data[2] ? {m_flag, 7'b0} : m_cfg);
          8'b0100_00??: m_wpend = 1'b1;
          default: ;
        endcase
      end
      dok = conv_done && m_run && !kill;
      if (dok) begin
        m_res = conv_result; m_flag = 1'b1;
        if (m_cfg_old[1]) m_pulse = 1'b1;
        else m_run = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [7:0] exp_d;
      bit bad;
      exp_d = (mq.size() != 0) ? mq[0] : 8'h00;
      checks++;
      bad = (cmd_ready !== (mq.size() == 0)) || (rd_valid !== (mq.size() != 0)) ||
            (conv_start !== m_pulse) || (drdy_n !== !m_flag) ||
            ((mq.size() != 0) && (rd_data !== exp_d));
      if (bad) begin
        errors++;
        $display("FAIL %s cycle model: rdy=%b vld=%b data=%h start=%b drdy_n=%b exp rdy=%b vld=%b data=%h start=%b drdy_n=%b",
                 cur_req, cmd_ready, rd_valid, rd_data, conv_start, drdy_n,
                 mq.size() == 0, mq.size() != 0, exp_d, m_pulse, !m_flag);
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic send(input logic [7:0] b);
    do tick(1); while (!cmd_ready);
    cmd_valid = 1'b1; cmd_data = b;
    tick(1);
    cmd_valid = 1'b0;
  endtask

  task automatic send_now(input logic [7:0] b);
    cmd_valid = 1'b1; cmd_data = b;
    tick(1);
    cmd_valid = 1'b0;
  endtask

  task automatic collect(input int n);
    int guard = 0;
    while (got_q.size() < n && guard < 40) begin tick(1); guard++; end
  endtask

  task automatic rd_reg(input logic [7:0] op, input logic [7:0] exp, input string req);
    got_q.delete();
    send(op);
    collect(1);
    check(got_q.size() == 1 && got_q[0] == exp, req, "register byte",
          (got_q.size() > 0) ? int'(got_q[0]) : -1, int'(exp));
  endtask

  task automatic rd_data3(input logic [7:0] op, input logic [23:0] exp, input string req);
    logic [23:0] got;
    got_q.delete();
    send(op);
    collect(3);
    got = (got_q.size() == 3) ? {got_q[0], got_q[1], got_q[2]} : 24'hxxxxxx;
    check(got_q.size() == 3 && got === exp, req, "result bytes msb first", int'(got), int'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] saved;
    logic [7:0]  held;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    cur_req = "R1";
    check(cmd_ready === 1'b1, "R1", "cmd_ready", cmd_ready, 1);
    check(rd_valid === 1'b0 && conv_start === 1'b0, "R1", "rd_valid|conv_start",
          {rd_valid, conv_start}, 0);
    check(drdy_n === 1'b1, "R1", "drdy_n", drdy_n, 1);
    rd_reg(8'h20, 8'h00, "R1");
    rd_reg(8'h24, 8'h00, "R1");

    // R7 config write, data byte looking like a command
    cur_req = "R7";
    send(8'h40); send(8'h06);
    rd_reg(8'h23, 8'h06, "R7");
    send(8'h43); send(8'hA5);
    rd_reg(8'h21, 8'hA5, "R7");

    // R12 undefined bytes
    cur_req = "R12";
    pulse_cnt = 0;
    send(8'h44); send(8'h55); send(8'h00); send(8'h0A); send(8'h30);
    tick(2);
    rd_reg(8'h20, 8'hA5, "R12");
    check(pulse_cnt == 0 && drdy_n === 1'b1, "R12", "no start, no flag", pulse_cnt, 0);

    // R8 single shot
    cur_req = "R8";
    send(8'h40); send(8'h00);
    pulse_cnt = 0;
    send(8'h09);
    tick(20);
    check(pulse_cnt == 1, "R8", "start pulses in single mode", pulse_cnt, 1);
    check(drdy_n === 1'b0, "R8", "drdy_n after completion", drdy_n, 0);
    cur_req = "R6";
    rd_reg(8'h25, 8'h80, "R6");
    cur_req = "R5";
    saved = m_res;
    rd_data3(8'h1F, saved, "R5");
    tick(1);
    check(drdy_n === 1'b1, "R5", "drdy_n after data read", drdy_n, 1);

    // R10 stray completion while idle
    cur_req = "R10";
    force_done = 1'b1; tick(1); force_done = 1'b0;
    tick(3);
    check(drdy_n === 1'b1, "R10", "drdy_n after stray done", drdy_n, 1);
    rd_data3(8'h10, saved, "R10");

    // R3 restart
    cur_req = "R3";
    pulse_cnt = 0; done_seen = 0;
    send(8'h08);
    tick(3);
    send(8'h08);
    tick(20);
    check(pulse_cnt == 2, "R3", "start pulses", pulse_cnt, 2);
    check(done_seen == 1, "R3", "completions after restart", done_seen, 1);

    // R9 continuous
    cur_req = "R9";
    send(8'h40); send(8'h02);
    pulse_cnt = 0;
    send(8'h08);
    tick(40);
    check(pulse_cnt >= 4, "R9", "automatic restarts", pulse_cnt, 4);

    // R13 read on the completion edge
    cur_req = "R13";
    while (conv_done !== 1'b1) tick(1);
    saved = m_res;
    got_q.delete();
    send_now(8'h12);
    collect(3);
    check(got_q.size() == 3 && {got_q[0], got_q[1], got_q[2]} == saved, "R13",
          "snapshot predates completion",
          (got_q.size() == 3) ? int'({got_q[0], got_q[1], got_q[2]}) : -1, int'(saved));
    check(drdy_n === 1'b0 || pulse_cnt > 0, "R13", "flag kept set", drdy_n, 0);

    // R4 power down with a conversion in flight
    cur_req = "R4";
    send(8'h03);
    pulse_cnt = 0;
    tick(20);
    check(pulse_cnt == 0, "R4", "start pulses after power-down", pulse_cnt, 0);
    saved = m_res;
    rd_data3(8'h1A, saved, "R4");
    force_done = 1'b1; tick(1); force_done = 1'b0;
    tick(3);
    rd_reg(8'h24, 8'h00, "R4");

    // R11 back-pressure
    cur_req = "R11";
    rd_ready = 1'b0;
    send(8'h1F);
    tick(1);
    held = rd_data;
    for (int i = 0; i < 5; i++) begin
      tick(1);
      check(rd_valid === 1'b1 && rd_data === held && cmd_ready === 1'b0, "R11",
            "stalled byte held", {rd_valid, cmd_ready, rd_data}, {2'b10, held});
    end
    rd_ready = 1'b1;
    tick(5);
    check(cmd_ready === 1'b1 && rd_valid === 1'b0, "R11", "drained", cmd_ready, 1);

    // R2 reset command
    cur_req = "R2";
    send(8'h40); send(8'h02);
    send(8'h08);
    tick(15);
    send(8'h07);
    pulse_cnt = 0;
    tick(15);
    check(pulse_cnt == 0, "R2", "start pulses after reset command", pulse_cnt, 0);
    check(drdy_n === 1'b1, "R2", "drdy_n", drdy_n, 1);
    rd_reg(8'h20, 8'h00, "R2");
    rd_data3(8'h11, 24'h0, "R2");

    tick(3);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule